// File: doc/BRIEF.md
# Asynchronous Byte SRAM Access Sequencer

This block sits between a synchronous request port and an external byte-wide asynchronous static memory. A caller presents an address, a direction flag and (for stores) a data byte. The sequencer then produces the active-low chip-select, output-enable and write-strobe waveforms, holds the address, and turns the shared data bus around. It returns the fetched byte together with a one-cycle acknowledge.

All memory timing limits are parameters in nanoseconds. They are turned into whole clock cycles against a clock-period parameter, so the same block serves different clock rates. A build-time option picks which strobe frames a store: the write strobe or the chip select. In either case the other strobe brackets it on both sides.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, chip select, output enable and write strobe are all high (inactive), acknowledge is low and the sequencer does not drive the data bus.
- R2: During a load, the write strobe stays high while chip select and output enable are low together; output enable and the write strobe are never low at the same time.
- R3: A load samples the bus no earlier than RD cycles after chip select and output enable fall. RD is the largest of the rounded-up address access, chip-select access, output-enable access and cycle-time limits, which is 4 cycles at 20 ns. The acknowledge of a load therefore comes RD+1 clock edges after the edge that accepts the request.
- R4: The sequencer drives the data bus only while output enable is high. It releases the bus in the same edge that ends a store, so output enable can never fall while the sequencer still drives.
- R5: In a store, the interval in which both strobes are low lasts at least W cycles. W is the largest of the rounded-up strobe pulse width, the data setup time and the cycle time minus two, which is 3 at 20 ns.
- R6: With WR_MODE=0 (write-strobe framed), chip select falls one cycle before the write strobe and rises DH cycles after it. With WR_MODE=1 (chip-select framed), the write strobe falls first and rises last in the same way. DH is the rounded-up data hold for the mode, with a minimum of one cycle.
- R7: The address stays constant from the first strobe fall until at least one cycle after the last strobe rise. The written byte is still on the bus in the cycle after the framing strobe rises.
- R8: Acknowledge is a one-cycle pulse. A store acknowledges 2+W+DH edges after the accepting edge. A request is taken only in the idle state.
- R9: Every nanosecond limit is rounded up to whole cycles, and any nonzero limit costs at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken only when idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to store |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Fetched byte, valid with rsp_ack on loads |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq | inout | DATA_W | Bidirectional memory data bus |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |

## Verification
The hardest case to bring about is an early sample of the bus on a load. A real memory model would hand over correct data at once and so hide a short access window. The bench's memory model therefore drives the inverted byte until the strobes have been low for RD cycles. Only a sequencer that waits the full window returns the stored value. Strobe ordering, overlap width and data hold at the framing edge are watched on two instances, one per write mode. Both instances receive the same random mix of loads and stores, with directed store-then-load pairs to the extreme addresses and back-to-back loads after stores.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WPRE,
      ST_WPULSE,
      ST_WPOST,
      ST_HOLD
   } seq_state_t;

   // R9: round a nanosecond limit up to whole clock cycles
   function automatic int ns_to_cyc(input int ns, input int per);
      if (ns <= 0) return 0;
      return (ns + per - 1) / per;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
   parameter int TW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          done
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (load)     cnt <= load_val;
      else if (cnt != 0) cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/sram_seq_iobuf.sv
module sram_seq_iobuf #(
   parameter int DW = 8
) (
   input  logic          drive,
   input  logic [DW-1:0] dout,
   output logic [DW-1:0] din,
   inout  wire  [DW-1:0] pad
);
   assign pad = drive ? dout : {DW{1'bz}};
   assign din = pad;
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W        = 21,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 20,
   parameter int T_CYCLE_NS    = 70,
   parameter int T_ADDR_ACC_NS = 70,
   parameter int T_CE_ACC_NS   = 70,
   parameter int T_OE_ACC_NS   = 35,
   parameter int T_WPULSE_NS   = 55,
   parameter int T_DSETUP_NS   = 30,
   parameter int T_DHOLD_WE_NS = 0,
   parameter int T_DHOLD_CE_NS = 10,
   parameter int T_AHOLD_WE_NS = 5,
   parameter int T_AHOLD_CE_NS = 15,
   parameter int WR_MODE       = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_ack,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   inout  wire  [DATA_W-1:0] mem_dq,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n
);
   localparam int RC_CYC = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);
   localparam int RD_CYC = imax(imax(ns_to_cyc(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_CE_ACC_NS, CLK_PERIOD_NS)),
                                imax(ns_to_cyc(T_OE_ACC_NS, CLK_PERIOD_NS), RC_CYC));
   localparam int W_CYC  = imax(imax(ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS)),
                                imax(RC_CYC - 2, 1));
   localparam int DH_CYC = imax(1, ns_to_cyc((WR_MODE == 0) ? T_DHOLD_WE_NS : T_DHOLD_CE_NS,
                                             CLK_PERIOD_NS));
   localparam int AH_CYC = imax(1, ns_to_cyc((WR_MODE == 0) ? T_AHOLD_WE_NS : T_AHOLD_CE_NS,
                                             CLK_PERIOD_NS));
   localparam int CMAX   = imax(imax(RD_CYC, W_CYC), imax(DH_CYC, AH_CYC));
   localparam int TW     = $clog2(CMAX + 1);

   if (CLK_PERIOD_NS < 1) begin : g_bad_period
      $error("CLK_PERIOD_NS must be positive");
   end
   if (WR_MODE != 0 && WR_MODE != 1) begin : g_bad_mode
      $error("WR_MODE must be 0 or 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("widths must be positive");
   end

   seq_state_t        state;
   logic              t_load, t_done;
   logic [TW-1:0]     t_val;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdat_q, din;
   logic              drv_q, rd_ce_n_q, oe_n_q, lead_n_q, term_n_q;

   sram_seq_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
   );

   sram_seq_iobuf #(.DW(DATA_W)) u_iobuf (
      .drive(drv_q), .dout(wdat_q), .din(din), .pad(mem_dq)
   );

   always_comb begin
      t_load = 1'b0;
      t_val  = '0;
      unique case (state)
         ST_IDLE:   if (req_valid) begin
                       t_load = 1'b1;
                       t_val  = req_write ? TW'(0) : TW'(RD_CYC - 1);
                    end
         ST_RD:     if (t_done) begin t_load = 1'b1; t_val = '0; end
         ST_WPRE:   if (t_done) begin t_load = 1'b1; t_val = TW'(W_CYC - 1); end
         ST_WPULSE: if (t_done) begin t_load = 1'b1; t_val = TW'(DH_CYC - 1); end
         ST_WPOST:  if (t_done) begin t_load = 1'b1; t_val = TW'(AH_CYC - 1); end
         default:   ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         addr_q    <= '0;
         wdat_q    <= '0;
         rsp_rdata <= '0;
         rsp_ack   <= 1'b0;
         drv_q     <= 1'b0;
         rd_ce_n_q <= 1'b1;
         oe_n_q    <= 1'b1;
         lead_n_q  <= 1'b1;
         term_n_q  <= 1'b1;
      end else begin
         unique case (state)
            ST_IDLE: begin
               rsp_ack <= 1'b0;
               if (req_valid) begin
                  addr_q <= req_addr;
                  wdat_q <= req_wdata;
                  if (req_write) begin
                     lead_n_q <= 1'b0;
                     drv_q    <= 1'b1;
                     state    <= ST_WPRE;
                  end else begin
                     rd_ce_n_q <= 1'b0;
                     oe_n_q    <= 1'b0;
                     state     <= ST_RD;
                  end
               end
            end
            ST_RD: if (t_done) begin
               rsp_rdata <= din;
               rd_ce_n_q <= 1'b1;
               oe_n_q    <= 1'b1;
               rsp_ack   <= 1'b1;
               state     <= ST_HOLD;
            end
            ST_WPRE: if (t_done) begin
               term_n_q <= 1'b0;
               state    <= ST_WPULSE;
            end
            ST_WPULSE: if (t_done) begin
               term_n_q <= 1'b1;
               state    <= ST_WPOST;
            end
            ST_WPOST: if (t_done) begin
               lead_n_q <= 1'b1;
               drv_q    <= 1'b0;
               rsp_ack  <= 1'b1;
               state    <= ST_HOLD;
            end
            ST_HOLD: begin
               rsp_ack <= 1'b0;
               if (t_done) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // mode variant: which strobe frames the store
   if (WR_MODE == 0) begin : g_we_framed
      assign mem_we_n = term_n_q;
      assign mem_ce_n = lead_n_q & rd_ce_n_q;
   end else begin : g_ce_framed
      assign mem_we_n = lead_n_q;
      assign mem_ce_n = term_n_q & rd_ce_n_q;
   end

   assign mem_oe_n = oe_n_q;
   assign mem_addr = addr_q;

   // ---------------- assertions ----------------
   logic [TW:0] ov_cnt;
   logic        ov_now;
   assign ov_now = !mem_we_n && !mem_ce_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       ov_cnt <= '0;
      else if (!ov_now)                 ov_cnt <= '0;
      else if (ov_cnt != {(TW+1){1'b1}}) ov_cnt <= ov_cnt + 1'b1;
   end

   a_r2_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   a_r4_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
      !(drv_q && !mem_oe_n));

   a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ack |=> !rsp_ack);

   a_r5_overlap_width: assert property (@(posedge clk) disable iff (!rst_n)
      (!ov_now && ov_cnt != 0) |-> (int'(ov_cnt) >= W_CYC));

   a_r8_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && state != ST_HOLD) |=> $stable(mem_addr));

endmodule

// File: tb/tb_sram_seq_ctrl.sv
module tb_sram_model #(
   parameter int MODE      = 0,
   parameter int AW        = 21,
   parameter int DW        = 8,
   parameter int KW        = 10,
   parameter int VALID_CNT = 3,
   parameter int W_MIN     = 3
) (
   input  logic          clk,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   inout  wire  [DW-1:0] dq,
   output int            n_order,
   output int            n_width,
   output int            n_oe,
   output int            n_addr,
   output int            n_hold
);
   logic [DW-1:0] mem [1 << KW];
   int            rcnt = 0;
   logic          p_ce = 1'b1, p_we = 1'b1, p_ov = 1'b0;
   logic [AW-1:0] p_addr = '0;
   logic [DW-1:0] wlat = '0;
   int            ovn = 0;
   logic          rd_on;
   logic [DW-1:0] rval;

   initial begin
      for (int i = 0; i < (1 << KW); i++) mem[i] = DW'(i * 37) ^ DW'(8'h5A);
      n_order = 0; n_width = 0; n_oe = 0; n_addr = 0; n_hold = 0;
   end

   assign rd_on = !ce_n && !oe_n && we_n;
   // drives the inverted byte until the access window has elapsed (R3)
   assign rval  = (rcnt >= VALID_CNT) ? mem[addr[KW-1:0]] : ~mem[addr[KW-1:0]];
   assign dq    = rd_on ? rval : {DW{1'bz}};

   always @(posedge clk) begin
      if (rd_on) rcnt <= rcnt + 1;
      else       rcnt <= 0;
   end

   always @(negedge clk) begin
      logic ov;
      ov = !we_n && !ce_n;
      if (!we_n && !oe_n) n_oe++;
      if (!ce_n && !p_ce && addr != p_addr) n_addr++;
      if (ce_n && !p_ce && addr != p_addr) n_addr++;
      if (ov) begin
         wlat = dq;
         ovn++;
         if (!p_ov) begin
            if (MODE == 0 && !(p_ce == 1'b0 && p_we == 1'b1)) n_order++;
            if (MODE == 1 && !(p_we == 1'b0 && p_ce == 1'b1)) n_order++;
         end
      end else if (p_ov) begin
         mem[addr[KW-1:0]] = wlat;
         if (ovn < W_MIN) n_width++;
         if (MODE == 0 && !(we_n && !ce_n)) n_order++;
         if (MODE == 1 && !(ce_n && !we_n)) n_order++;
         if (dq !== wlat) n_hold++;
         ovn = 0;
      end
      p_ov   = ov;
      p_ce   = ce_n;
      p_we   = we_n;
      p_addr = addr;
   end
endmodule

module tb_sram_seq_ctrl;
   localparam int AW = 21;
   localparam int DW = 8;
   localparam int KW = 10;
   localparam int PER = 20;

   function automatic int cyc(input int ns);
      if (ns <= 0) return 0;
      return (ns + PER - 1) / PER;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int E_RD = mx(mx(cyc(70), cyc(70)), mx(cyc(35), cyc(70)));
   localparam int E_W  = mx(mx(cyc(55), cyc(30)), cyc(70) - 2);
   localparam int E_DH0 = mx(1, cyc(0));
   localparam int E_DH1 = mx(1, cyc(10));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(PER/2) clk = ~clk;

   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;

   logic          ack0, ack1, ce0, ce1, oe0, oe1, we0, we1;
   logic [DW-1:0] rd0, rd1;
   logic [AW-1:0] ma0, ma1;
   wire  [DW-1:0] dq0, dq1;
   int o0, w0, e0, a0, h0, o1, w1, e1, a1, h1;

   int checks = 0, errors = 0;
   logic [DW-1:0] shadow [1 << KW];

   sram_seq_ctrl #(.WR_MODE(0)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ack(ack0), .rsp_rdata(rd0),
      .mem_addr(ma0), .mem_dq(dq0), .mem_ce_n(ce0), .mem_oe_n(oe0), .mem_we_n(we0));

   sram_seq_ctrl #(.WR_MODE(1)) dut_ce (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ack(ack1), .rsp_rdata(rd1),
      .mem_addr(ma1), .mem_dq(dq1), .mem_ce_n(ce1), .mem_oe_n(oe1), .mem_we_n(we1));

   tb_sram_model #(.MODE(0), .VALID_CNT(E_RD - 1), .W_MIN(E_W)) m0 (
      .clk(clk), .ce_n(ce0), .oe_n(oe0), .we_n(we0), .addr(ma0), .dq(dq0),
      .n_order(o0), .n_width(w0), .n_oe(e0), .n_addr(a0), .n_hold(h0));

   tb_sram_model #(.MODE(1), .VALID_CNT(E_RD - 1), .W_MIN(E_W)) m1 (
      .clk(clk), .ce_n(ce1), .oe_n(oe1), .we_n(we1), .addr(ma1), .dq(dq1),
      .n_order(o1), .n_width(w1), .n_oe(e1), .n_addr(a1), .n_hold(h1));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int k0 = 0, k1 = 0;
      int exp_lat0, exp_lat1;
      logic [DW-1:0] exp_rd;
      exp_rd = shadow[a[KW-1:0]];
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      for (int k = 1; k <= 40; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (ack0 && k0 == 0) k0 = k;
         if (ack1 && k1 == 0) k1 = k;
         if (k0 != 0 && k1 != 0) break;
      end
      req_valid = 1'b0;
      exp_lat0 = wr ? (2 + E_W + E_DH0) : (E_RD + 1);
      exp_lat1 = wr ? (2 + E_W + E_DH1) : (E_RD + 1);
      if (wr) begin
         check(k0 == exp_lat0, "R8 store latency (we-framed)", k0, exp_lat0);
         check(k1 == exp_lat1, "R8 store latency (ce-framed)", k1, exp_lat1);
         shadow[a[KW-1:0]] = d;
      end else begin
         check(k0 == exp_lat0, "R3 load latency", k0, exp_lat0);
         check(k1 == exp_lat1, "R3 load latency (ce-framed)", k1, exp_lat1);
         check(rd0 == exp_rd, "R3 load data", rd0, exp_rd);
         check(rd1 == exp_rd, "R3 load data (ce-framed)", rd1, exp_rd);
      end
      @(negedge clk);
      check(!ack0 && !ack1, "R8 ack one cycle", ack0, 0);
   endtask

   initial begin
      #(PER * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd7411);
      for (int i = 0; i < (1 << KW); i++) shadow[i] = DW'(i * 37) ^ DW'(8'h5A);
      repeat (3) @(negedge clk);
      // R1: reset state
      check(ce0 && oe0 && we0 && !ack0, "R1 strobes idle in reset", {ce0, oe0, we0, ack0}, 4'b1110);
      rst_n = 1'b1;
      @(negedge clk);
      check(ce1 && oe1 && we1 && !ack1, "R1 strobes idle after reset", {ce1, oe1, we1, ack1}, 4'b1110);

      // directed corners: extreme addresses, store then load, back-to-back loads
      access(1'b0, 21'h000000, 8'h00);
      access(1'b1, 21'h000000, 8'hA5);
      access(1'b0, 21'h000000, 8'h00);
      access(1'b1, 21'h1FFFFF, 8'h3C);
      access(1'b0, 21'h1FFFFF, 8'h00);
      access(1'b0, 21'h1FFFFF, 8'h00);
      access(1'b1, 21'h0003FF, 8'hFF);
      access(1'b1, 21'h0003FF, 8'h00);
      access(1'b0, 21'h0003FF, 8'h00);

      // constrained random mix
      for (int n = 0; n < 120; n++) begin
         logic [AW-1:0] ra;
         ra = AW'($urandom);
         if (n % 3 == 0) ra[KW-1:0] = KW'($urandom_range(0, 7));
         access(1'($urandom_range(0, 1)), ra, DW'($urandom));
      end

      // monitor summaries
      check(e0 == 0 && e1 == 0, "R2 oe and we never both low", e0 + e1, 0);
      check(w0 == 0 && w1 == 0, "R5 store overlap width", w0 + w1, 0);
      check(o0 == 0, "R6 strobe order we-framed", o0, 0);
      check(o1 == 0, "R6 strobe order ce-framed", o1, 0);
      check(a0 == 0 && a1 == 0, "R7 address stable", a0 + a1, 0);
      check(h0 == 0 && h1 == 0, "R7 data held at framing edge", h0 + h1, 0);
      // R4 and R9 are covered by the load data and latency checks above
      check(E_DH0 == 1 && E_W == 3 && E_RD == 4, "R9 rounding", E_W, 3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule